// File: doc/BRIEF.md
# Mailbox Doorbell and Interrupt Register Block

This block is the register front end of a shared-memory mailbox endpoint. Software reaches four 32-bit words through a small memory-mapped window: an interrupt enable word, an interrupt cause word, a read-only word giving this endpoint's own peer number, and a doorbell word. The wired interrupt output is high while any cause bit is also enabled. Reading the cause word returns it and empties it in the same access.

Writing the doorbell word asks for a notification to another peer. The destination peer number sits in the upper half of the written word and the vector sits in the low byte. The block checks both against the live peer count and that peer's vector count, which arrive on input ports. It emits a one-cycle event carrying the two values only when both are in range. A notification arriving for this endpoint on `evt_in` sets the cause word to 1 when the endpoint uses its wired interrupt. When message-signalled mode is selected, or no interrupt pin is present, the wired line stays low.

Top module: `mbx_doorbell_regs`

## Requirements
- R1: After reset the enable word and the cause word are 0, `irq` is low and `db_valid` is low.
- R2: A write to word offset 0x0 loads the enable word with the full written value, and a read at 0x0 returns it.
- R3: A write to word offset 0x4 loads the cause word with the written value. When `msi_mode` is 0 and `irq_pin_en` is 1, `irq` is 1 exactly when the cause AND enable words are nonzero, from the cycle after the write.
- R4: A read at 0x4 returns the current cause word on `rd_data` in the access cycle and leaves the cause word 0 from the next cycle, with `irq` falling then.
- R5: A read at 0x8 returns `own_id` zero-extended to 32 bits. Writes to 0x8 change no state.
- R6: Reads of 0xC, of any offset at or above 0x10, or of any offset whose two low bits are nonzero return 0. Writes at or above 0x10 change no state.
- R7: Writes ignore the two low address bits: a write to 0x1–0x3 acts on the enable word and a write to 0xD–0xF acts as a doorbell.
- R8: A doorbell write takes the peer from bits 31:16 and the vector from bits 7:0, ignores bits 15:8, and raises `db_valid` for exactly the one cycle after the write, with `db_peer` and `db_vec` holding those values.
- R9: A doorbell write whose peer is not below `peer_count`, or not below MAX_PEERS, raises no `db_valid`.
- R10: A doorbell write whose vector is not below that peer's count in `peer_vcnt` raises no `db_valid`. Peer p's count is bits [9p+8:9p].
- R11: A cycle with `evt_in` high and `msi_mode` low sets the cause word to 1. With `msi_mode` high, `evt_in` leaves the cause word unchanged.
- R12: When `evt_in` coincides with a cause read or a cause write, the cause word ends at 1. The read still returns the old value.
- R13: `irq` is low whenever `msi_mode` is 1 or `irq_pin_en` is 0, whatever the cause and enable words hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access in this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 8 | Byte offset inside the window |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid in the access cycle |
| own_id | input | 16 | This endpoint's peer number |
| peer_count | input | 16 | Number of peers currently known |
| peer_vcnt | input | 72 | Per-peer vector counts, 9 bits each, peer 0 lowest |
| evt_in | input | 1 | Incoming notification for this endpoint |
| msi_mode | input | 1 | Message-signalled mode; silences the wired line |
| irq_pin_en | input | 1 | Wired interrupt pin present |
| irq | output | 1 | Level interrupt |
| db_valid | output | 1 | One-cycle doorbell event |
| db_peer | output | 16 | Destination peer of the event |
| db_vec | output | 8 | Vector of the event |

## Verification
A cause word that failed to clear would show on the very next read of 0x4, and `irq` would stay high one cycle after the read when it should have fallen. A wrong range check or a wrong slice of the vector count table shows as a present or missing `db_valid` in the single cycle after a doorbell write. Sweeping every peer and vector pair of a small table catches a mis-indexed count at once. Enable and cause corruption appears on `irq` one cycle after the offending write.

// File: rtl/mbx_db_pkg.sv
package mbx_db_pkg;
  localparam int DATA_W   = 32;
  localparam int PEER_W   = 16;
  localparam int VEC_W    = 8;
  localparam int VCNT_W   = VEC_W + 1;
  localparam int PEER_LSB = 16;
  localparam int NUM_REGS = 4;
  // word index = byte offset / 4
  localparam int IDX_MASK = 0;
  localparam int IDX_STAT = 1;
  localparam int IDX_POS  = 2;
  localparam int IDX_BELL = 3;
endpackage

// File: rtl/mbx_db_decode.sv
module mbx_db_decode
  import mbx_db_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [NUM_REGS-1:0] wr_hit,
  output logic [NUM_REGS-1:0] rd_hit
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word_idx;
  logic              aligned;

  assign word_idx = req_addr[ADDR_W-1:2];
  assign aligned  = (req_addr[1:0] == 2'b00);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    // writes drop the two low bits; reads need an aligned offset
    assign wr_hit[i] = req_valid && req_write && (word_idx == WORD_W'(i));
    assign rd_hit[i] = req_valid && !req_write && aligned && (word_idx == WORD_W'(i));
  end
endmodule

// File: rtl/mbx_db_intr.sv
module mbx_db_intr
  import mbx_db_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mask,
  input  logic              wr_stat,
  input  logic              rd_stat,
  input  logic [DATA_W-1:0] wdata,
  input  logic              evt_in,
  input  logic              msi_mode,
  input  logic              irq_pin_en,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] stat_q,
  output logic              irq
);
  logic [DATA_W-1:0] mask_d;
  logic [DATA_W-1:0] stat_d;
  logic              mask_en;
  logic              stat_en;
  logic              evt_wired;

  assign evt_wired = evt_in && !msi_mode;
  assign mask_en   = wr_mask;
  assign stat_en   = wr_stat || rd_stat || evt_wired;

  always_comb begin
    mask_d = wdata;
    stat_d = stat_q;
    if (rd_stat) stat_d = '0;
    if (wr_stat) stat_d = wdata;
    if (evt_wired) stat_d = DATA_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (mask_en) mask_q <= mask_d;
      if (stat_en) stat_q <= stat_d;
    end
  end

  assign irq = irq_pin_en && !msi_mode && (|(stat_q & mask_q));

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n) wr_mask |=> (mask_q == $past(wdata))); // R2
  AST_STAT_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (wr_stat && !evt_wired) |=> (stat_q == $past(wdata))); // R3
  AST_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (rd_stat && !evt_wired) |=> (stat_q == '0)); // R4
  AST_EVT_SET: assert property (@(posedge clk) disable iff (!rst_n) evt_wired |=> (stat_q == DATA_W'(1))); // R12
  AST_MSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (evt_in && msi_mode && !wr_stat && !rd_stat) |=> $stable(stat_q)); // R11
endmodule

// File: rtl/mbx_db_bell.sv
module mbx_db_bell
  import mbx_db_pkg::*;
#(
  parameter int MAX_PEERS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_bell,
  input  logic [PEER_W-1:0]           dest_in,
  input  logic [VEC_W-1:0]            vec_in,
  input  logic [PEER_W-1:0]           peer_count,
  input  logic [MAX_PEERS*VCNT_W-1:0] peer_vcnt,
  output logic                        db_valid,
  output logic [PEER_W-1:0]           db_peer,
  output logic [VEC_W-1:0]            db_vec
);
  localparam int CMP_W = PEER_W + 1;

  logic [MAX_PEERS-1:0] vec_ok_p;
  logic                 dest_ok;
  logic                 fire;
  logic                 valid_d;
  logic [PEER_W-1:0]    peer_d;
  logic [VEC_W-1:0]     vec_d;

  // per-peer vector range test, only the addressed peer can match
  for (genvar p = 0; p < MAX_PEERS; p++) begin : g_peer
    logic [VCNT_W-1:0] cnt;
    assign cnt         = peer_vcnt[p*VCNT_W +: VCNT_W];
    assign vec_ok_p[p] = (dest_in == PEER_W'(p)) && ({1'b0, vec_in} < cnt);
  end

  assign dest_ok = (dest_in < peer_count) && ({1'b0, dest_in} < CMP_W'(MAX_PEERS));
  assign fire    = wr_bell && dest_ok && (|vec_ok_p);

  always_comb begin
    valid_d = fire;
    peer_d  = dest_in;
    vec_d   = vec_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_valid <= 1'b0;
      db_peer  <= '0;
      db_vec   <= '0;
    end else begin
      db_valid <= valid_d;
      if (fire) begin
        db_peer <= peer_d;
        db_vec  <= vec_d;
      end
    end
  end

  AST_DB_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) db_valid |-> $past(wr_bell)); // R8
  AST_DB_FIELDS: assert property (@(posedge clk) disable iff (!rst_n) db_valid |-> (db_peer == $past(dest_in) && db_vec == $past(vec_in))); // R8
  AST_DB_PEER_RANGE: assert property (@(posedge clk) disable iff (!rst_n) db_valid |-> (db_peer < $past(peer_count))); // R9
endmodule

// File: rtl/mbx_doorbell_regs.sv
module mbx_doorbell_regs
  import mbx_db_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int MAX_PEERS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [DATA_W-1:0]           req_wdata,
  output logic [DATA_W-1:0]           rd_data,
  input  logic [PEER_W-1:0]           own_id,
  input  logic [PEER_W-1:0]           peer_count,
  input  logic [MAX_PEERS*VCNT_W-1:0] peer_vcnt,
  input  logic                        evt_in,
  input  logic                        msi_mode,
  input  logic                        irq_pin_en,
  output logic                        irq,
  output logic                        db_valid,
  output logic [PEER_W-1:0]           db_peer,
  output logic [VEC_W-1:0]            db_vec
);
  logic [1:0]          rsync_q;
  logic                core_rst_n;
  logic [NUM_REGS-1:0] wr_hit;
  logic [NUM_REGS-1:0] rd_hit;
  logic [DATA_W-1:0]   mask_q;
  logic [DATA_W-1:0]   stat_q;
  logic                unused_strobes;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign core_rst_n = rsync_q[1];

  mbx_db_decode #(.ADDR_W(ADDR_W)) u_decode (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .wr_hit    (wr_hit),
    .rd_hit    (rd_hit)
  );

  mbx_db_intr u_intr (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .wr_mask    (wr_hit[IDX_MASK]),
    .wr_stat    (wr_hit[IDX_STAT]),
    .rd_stat    (rd_hit[IDX_STAT]),
    .wdata      (req_wdata),
    .evt_in     (evt_in),
    .msi_mode   (msi_mode),
    .irq_pin_en (irq_pin_en),
    .mask_q     (mask_q),
    .stat_q     (stat_q),
    .irq        (irq)
  );

  mbx_db_bell #(.MAX_PEERS(MAX_PEERS)) u_bell (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .wr_bell    (wr_hit[IDX_BELL]),
    .dest_in    (req_wdata[DATA_W-1:PEER_LSB]),
    .vec_in     (req_wdata[VEC_W-1:0]),
    .peer_count (peer_count),
    .peer_vcnt  (peer_vcnt),
    .db_valid   (db_valid),
    .db_peer    (db_peer),
    .db_vec     (db_vec)
  );

  // the position word is read-only and the doorbell word reads as zero
  assign unused_strobes = ^{wr_hit[IDX_POS], rd_hit[IDX_BELL]};

  always_comb begin
    rd_data = '0;
    if (rd_hit[IDX_MASK]) rd_data = mask_q;
    if (rd_hit[IDX_STAT]) rd_data = stat_q;
    if (rd_hit[IDX_POS])  rd_data = DATA_W'(own_id);
  end

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!core_rst_n) (msi_mode || !irq_pin_en) |-> !irq); // R13
  AST_IRQ_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!core_rst_n) (rd_hit[IDX_STAT] && !evt_in) |=> !irq); // R4
  AST_READ_ZERO_HIGH: assert property (@(posedge clk) disable iff (!core_rst_n) (req_valid && !req_write && (req_addr[ADDR_W-1:4] != '0)) |-> (rd_data == '0)); // R6
endmodule

// File: tb/mbx_doorbell_regs_tb.sv
`timescale 1ns/1ps
module mbx_doorbell_regs_tb;
  localparam int MAXP = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata;
  logic [31:0] rd_data;
  logic [15:0] own_id, peer_count;
  logic [MAXP*9-1:0] peer_vcnt;
  logic        evt_in, msi_mode, irq_pin_en;
  logic        irq, db_valid;
  logic [15:0] db_peer;
  logic [7:0]  db_vec;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  mbx_doorbell_regs u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .own_id(own_id), .peer_count(peer_count), .peer_vcnt(peer_vcnt),
    .evt_in(evt_in), .msi_mode(msi_mode), .irq_pin_en(irq_pin_en),
    .irq(irq), .db_valid(db_valid), .db_peer(db_peer), .db_vec(db_vec)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    #1 d = rd_data;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic        expv;
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    own_id = 16'h0003; peer_count = 16'd5; evt_in = 0; msi_mode = 0; irq_pin_en = 1;
    for (int p = 0; p < MAXP; p++) peer_vcnt[p*9 +: 9] = 9'(p + 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 db_valid", {31'b0, db_valid}, 0);
    bus_rd(8'h00, d); check("R1 mask", d, 0);
    bus_rd(8'h04, d); check("R1 status", d, 0);

    // R2 / R3 full enable x cause sweep on 4 bits
    for (int m = 0; m < 16; m++) begin
      for (int s = 0; s < 16; s++) begin
        bus_wr(8'h00, 32'(m));
        bus_wr(8'h04, 32'(s));
        check("R3 irq", {31'b0, irq}, ((m & s) != 0) ? 1 : 0);
      end
    end
    bus_wr(8'h00, 32'hDEAD_BEEF);
    bus_rd(8'h00, d); check("R2 mask readback", d, 32'hDEAD_BEEF);

    // R4 read-clear
    bus_wr(8'h00, 32'hFFFF_FFFF);
    bus_wr(8'h04, 32'h0000_0A50);
    check("R3 irq set", {31'b0, irq}, 1);
    bus_rd(8'h04, d); check("R4 read value", d, 32'h0000_0A50);
    check("R4 irq after read", {31'b0, irq}, 0);
    bus_rd(8'h04, d); check("R4 cleared", d, 0);

    // R5 position
    bus_rd(8'h08, d); check("R5 own id", d, 32'h3);
    bus_wr(8'h08, 32'h1234_5678);
    bus_rd(8'h08, d); check("R5 write ignored", d, 32'h3);
    bus_rd(8'h00, d); check("R5 mask untouched", d, 32'hFFFF_FFFF);

    // R6 unmapped / misaligned reads and unmapped writes
    bus_wr(8'h04, 32'h77);
    bus_rd(8'h0C, d); check("R6 doorbell reads 0", d, 0);
    bus_rd(8'h01, d); check("R6 misaligned read", d, 0);
    bus_rd(8'h10, d); check("R6 read 0x10", d, 0);
    bus_rd(8'hFC, d); check("R6 read 0xFC", d, 0);
    bus_wr(8'h10, 32'h0);
    bus_wr(8'h44, 32'h0);
    check("R6 no doorbell from 0x44", {31'b0, db_valid}, 0);
    bus_rd(8'h00, d); check("R6 mask after unmapped wr", d, 32'hFFFF_FFFF);
    bus_rd(8'h04, d); check("R6 status after unmapped wr", d, 32'h77);

    // R7 low address bits ignored on writes
    bus_wr(8'h02, 32'h0000_00A5);
    bus_rd(8'h00, d); check("R7 write 0x2 hits mask", d, 32'hA5);
    bus_wr(8'h0D, {16'd1, 8'h00, 8'd1});
    check("R7 doorbell via 0xD", {31'b0, db_valid}, 1);

    // R8 / R9 / R10 doorbell sweep, bits 15:8 carry junk
    for (int dst = 0; dst < MAXP; dst++) begin
      for (int v = 0; v < MAXP; v++) begin
        bus_wr(8'h0C, {16'(dst), 8'((dst * 37 + v * 11) | 8'h80), 8'(v)});
        expv = (dst < 5) && (v < dst + 1);
        check(dst >= 5 ? "R9 peer range" : "R10 vector range", {31'b0, db_valid}, {31'b0, expv});
        if (expv) begin
          check("R8 peer", {16'b0, db_peer}, 32'(dst));
          check("R8 vec", {24'b0, db_vec}, 32'(v));
        end
      end
    end
    bus_wr(8'h0C, {16'h8002, 8'h00, 8'd0});
    check("R9 large peer", {31'b0, db_valid}, 0);
    peer_count = 16'd200;
    bus_wr(8'h0C, {16'd8, 8'h00, 8'd0});
    check("R9 peer beyond table", {31'b0, db_valid}, 0);
    bus_wr(8'h0C, {16'd7, 8'hFF, 8'd7});
    check("R10 top vector", {31'b0, db_valid}, 1);
    @(negedge clk);
    check("R8 one-cycle pulse", {31'b0, db_valid}, 0);
    bus_wr(8'h0C, {16'd7, 8'h00, 8'd8});
    check("R10 vector equals count", {31'b0, db_valid}, 0);

    // R11 event in wired mode
    bus_wr(8'h04, 32'h0);
    bus_wr(8'h00, 32'h1);
    @(negedge clk); evt_in = 1'b1;
    @(negedge clk); evt_in = 1'b0;
    check("R11 irq from event", {31'b0, irq}, 1);
    bus_rd(8'h04, d); check("R11 status is 1", d, 1);

    // R11 event in msi mode leaves status
    bus_wr(8'h04, 32'h30);
    msi_mode = 1'b1;
    @(negedge clk); evt_in = 1'b1;
    @(negedge clk); evt_in = 1'b0;
    bus_rd(8'h04, d); check("R11 msi event ignored", d, 32'h30);
    msi_mode = 1'b0;

    // R12 event coincides with read and with write
    bus_wr(8'h04, 32'h6);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 8'h04; evt_in = 1;
    #1 d = rd_data;
    @(negedge clk);
    req_valid = 0; evt_in = 0;
    check("R12 read returns old", d, 32'h6);
    bus_rd(8'h04, d); check("R12 event beats clear", d, 1);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 8'h04; req_wdata = 32'hF0; evt_in = 1;
    @(negedge clk);
    req_valid = 0; req_write = 0; evt_in = 0;
    bus_rd(8'h04, d); check("R12 event beats write", d, 1);

    // R13 wired line silenced
    bus_wr(8'h00, 32'hFFFF_FFFF);
    bus_wr(8'h04, 32'hFFFF_FFFF);
    check("R13 baseline irq", {31'b0, irq}, 1);
    @(negedge clk); irq_pin_en = 1'b0;
    #1 check("R13 no pin", {31'b0, irq}, 0);
    @(negedge clk); irq_pin_en = 1'b1; msi_mode = 1'b1;
    #1 check("R13 msi mode", {31'b0, irq}, 0);
    @(negedge clk); msi_mode = 1'b0;
    #1 check("R13 restored", {31'b0, irq}, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule